// File: doc/BRIEF.md
# Register-List Memory Micro-op Sequencer

This block turns a single multi-register load or store instruction into a series of single-register memory micro-ops for a simple in-order pipeline. The decode stage gives it a register-list mask, a base address, a direction and a stack-form flag, and pulses start. The sequencer then walks the selected registers from the lowest index to the highest. For each one it presents a register index, a word address and a valid strobe, and it moves to the next register only when the downstream stage signals ready.

A fault report that arrives while a sequence is running stops it precisely. No further micro-op is offered, a one-cycle abort pulse is raised, and the base register is left unwritten, so the same instruction can be issued again and replayed from its first register. This full replay is how the stack forms (push and pop) recover. A sequence may fault on its early or its late part, on any number of attempts, and each fresh start is accepted.

On normal completion the block raises a one-cycle done pulse. When writeback is enabled it presents the updated base address on that same cycle.

Top module: `mreg_seq`

## Requirements
- R1: After reset, uop_valid_o, busy_o, done_o, abort_o and wb_valid_o are all 0.
- R2: A start accepted while idle produces exactly one micro-op for each set bit of mask_i, with uop_reg_o equal to the bit position, in strictly increasing order. The first micro-op is valid on the cycle after start.
- R3: Micro-op k (counting from 0) has address first + 4*k. For a stack store (store_i=1, stack_i=1, push) first is base - 4*n, where n is the number of set bits (pre-decrement). For every other form first is base. uop_store_o equals the captured store_i (1 = store, 0 = load).
- R4: While uop_valid_o is 1 and ready_i is 0 (with no fault), the next cycle presents the same register index and address.
- R5: A start with an all-zero mask issues no micro-op and raises done_o on the cycle after start.
- R6: done_o is raised for one cycle on the cycle after the final micro-op is accepted (valid, ready and no fault). On that cycle wb_valid_o equals the captured wb_en_i, and wb_addr_o is base - 4*n for a push and base + 4*n otherwise. For an empty mask the written-back address is base.
- R7: fault_i while a micro-op is valid makes the next cycle show uop_valid_o=0, abort_o=1, done_o=0 and wb_valid_o=0. The abort lasts one cycle and the block returns to idle. fault_i takes priority over ready_i.
- R8: After an abort, a new start with the same operands replays the whole sequence from its first register and base address. This holds across any number of successive aborted attempts.
- R9: start_i is ignored while a sequence is running. The ongoing micro-op stream is unchanged.
- R10: fault_i while no micro-op is valid has no effect, and no abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence (taken only while idle) |
| store_i | input | 1 | Direction: 1 = store, 0 = load |
| stack_i | input | 1 | Stack form: base is the stack pointer; a stack store pre-decrements |
| wb_en_i | input | 1 | Present the updated base on completion |
| mask_i | input | NREG | Register-list mask, bit i selects register i |
| base_i | input | AW | Base address |
| ready_i | input | 1 | Downstream accepts the current micro-op |
| fault_i | input | 1 | Fault report; aborts a running sequence |
| uop_valid_o | output | 1 | Micro-op valid |
| uop_store_o | output | 1 | Micro-op direction |
| uop_reg_o | output | log2(NREG) | Register index of the micro-op |
| uop_addr_o | output | AW | Word address of the micro-op |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| wb_valid_o | output | 1 | Base writeback strobe (with done_o) |
| wb_addr_o | output | AW | Updated base address |

## Verification
The embedded properties check on every cycle the local stepping rules. Under a stall the index and address hold. Each accepted micro-op is followed by a higher index and an address one word up. A fault is followed by an abort and no valid, a final acceptance is followed by done, an empty mask by immediate done, and an idle fault by no abort. Whether the stream as a whole has the right length, the right first address for push versus the other forms, and the right written-back base can only be seen by the bench. It sweeps every 8-bit mask under all four direction and stack combinations with irregular ready patterns. Replay after repeated aborts at early and late positions, and starts poked in mid-sequence, also rest on the bench scenarios.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

  typedef struct packed {
    logic store;
    logic wb_en;
  } seq_ctl_t;
endpackage

// File: rtl/seq_popcnt.sv
module seq_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/seq_lowpick.sv
module seq_lowpick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o,
  output logic          any_o,
  output logic          last_o
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - W'(1));
  assign any_o  = |mask_i;
  assign last_o = any_o && (rest_o == '0);

  // R2: the picked index is set and no lower bit is set
  always_comb begin
    if (any_o === 1'b1) begin
      p_lowest_r2: assert (mask_i[idx_o] && ((mask_i & ((W'(1) << idx_o) - W'(1))) == '0));
    end
  end
endmodule

// File: rtl/seq_addr_plan.sv
module seq_addr_plan #(
  parameter int AW         = 32,
  parameter int CW         = 5,
  parameter int STEP_BYTES = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          predec_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP_BYTES);

  logic [AW-1:0] span;

  assign span    = AW'(cnt_i) * STEP_A;
  assign final_o = predec_i ? (base_i - span) : (base_i + span);
  assign first_o = predec_i ? final_o : base_i;
endmodule

// File: rtl/mreg_seq.sv
module mreg_seq
  import seq_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    store_i,
  input  logic                    stack_i,
  input  logic                    wb_en_i,
  input  logic [NREG-1:0]         mask_i,
  input  logic [AW-1:0]           base_i,
  input  logic                    ready_i,
  input  logic                    fault_i,
  output logic                    uop_valid_o,
  output logic                    uop_store_o,
  output logic [$clog2(NREG)-1:0] uop_reg_o,
  output logic [AW-1:0]           uop_addr_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    abort_o,
  output logic                    wb_valid_o,
  output logic [AW-1:0]           wb_addr_o
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [AW-1:0] STEP_A = AW'(STEP_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  // state
  seq_state_e    state_q, state_d;
  logic          done_q, done_d;
  logic          abort_q, abort_d;
  logic          wbv_q, wbv_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] wbaddr_q, wbaddr_d;
  seq_ctl_t      ctl_q, ctl_d;

  // helpers
  logic [CW-1:0]   sel_cnt;
  logic [AW-1:0]   first_addr, final_addr;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_rest;
  logic            pick_any, pick_last;

  seq_popcnt #(.W(NREG), .CW(CW)) u_cnt (
    .vec_i (mask_i),
    .cnt_o (sel_cnt)
  );

  seq_addr_plan #(.AW(AW), .CW(CW), .STEP_BYTES(STEP_BYTES)) u_plan (
    .base_i   (base_i),
    .cnt_i    (sel_cnt),
    .predec_i (stack_i & store_i),
    .first_o  (first_addr),
    .final_o  (final_addr)
  );

  seq_lowpick #(.W(NREG), .IW(IW)) u_pick (
    .mask_i (pend_q),
    .idx_o  (pick_idx),
    .rest_o (pick_rest),
    .any_o  (pick_any),
    .last_o (pick_last)
  );

  // clock enables
  logic running, cap_en, adv_en, abt_en, data_en;
  assign running = (state_q == ST_RUN);
  assign cap_en  = !running && start_i;
  assign abt_en  = running && fault_i;
  assign adv_en  = running && ready_i && !fault_i;
  assign data_en = cap_en || adv_en;

  // next state
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    addr_d   = addr_q;
    wbaddr_d = wbaddr_q;
    ctl_d    = ctl_q;
    done_d   = 1'b0;
    abort_d  = 1'b0;
    wbv_d    = 1'b0;
    if (cap_en) begin
      pend_d      = mask_i;
      addr_d      = first_addr;
      wbaddr_d    = final_addr;
      ctl_d.store = store_i;
      ctl_d.wb_en = wb_en_i;
      if (sel_cnt == '0) begin
        done_d = 1'b1;
        wbv_d  = wb_en_i;
      end else begin
        state_d = ST_RUN;
      end
    end else if (abt_en) begin
      state_d = ST_IDLE;
      abort_d = 1'b1;
    end else if (adv_en) begin
      pend_d = pick_rest;
      addr_d = addr_q + STEP_A;
      if (pick_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        wbv_d   = ctl_q.wb_en;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      wbv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      abort_q <= abort_d;
      wbv_q   <= wbv_d;
    end
  end

  // datapath registers, no reset, explicit enables
  always_ff @(posedge clk) begin
    if (data_en) begin
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
    if (cap_en) begin
      wbaddr_q <= wbaddr_d;
      ctl_q    <= ctl_d;
    end
  end

  assign uop_valid_o = running;
  assign uop_store_o = ctl_q.store;
  assign uop_reg_o   = pick_idx;
  assign uop_addr_o  = addr_q;
  assign busy_o      = running;
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign wb_valid_o  = wbv_q;
  assign wb_addr_o   = wbaddr_q;

  // properties
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    uop_valid_o && !ready_i && !fault_i |=> uop_valid_o && $stable(uop_reg_o) && $stable(uop_addr_o));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    uop_valid_o && ready_i && !fault_i && !pick_last |=> uop_valid_o && (uop_addr_o == $past(uop_addr_o) + STEP_A));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    uop_valid_o && ready_i && !fault_i && !pick_last |=> uop_reg_o > $past(uop_reg_o));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    uop_valid_o && ready_i && !fault_i && pick_last |=> done_o && !uop_valid_o);

  p_wbdone_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    wb_valid_o |-> done_o);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    uop_valid_o && fault_i |=> abort_o && !uop_valid_o && !done_o && !wb_valid_o);

  p_abort_once_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    abort_o |=> !abort_o);

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    !uop_valid_o && start_i && (mask_i == '0) |=> done_o && !uop_valid_o);

  p_idle_fault_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    !uop_valid_o && fault_i |=> !abort_o);
endmodule

// File: tb/sim_mreg_seq.sv
`timescale 1ns/1ps
module sim_mreg_seq;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, store_i, stack_i, wb_en_i, ready_i, fault_i;
  logic [NR-1:0] mask_i;
  logic [31:0] base_i;
  logic        uop_valid_o, uop_store_o, busy_o, done_o, abort_o, wb_valid_o;
  logic [2:0]  uop_reg_o;
  logic [31:0] uop_addr_o, wb_addr_o;

  int          nchk = 0;
  int          nfail = 0;
  int unsigned cyc = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  mreg_seq #(.NREG(NR), .AW(32), .STEP_BYTES(4)) u0 (
    .clk, .rst_n, .start_i, .store_i, .stack_i, .wb_en_i, .mask_i, .base_i,
    .ready_i, .fault_i, .uop_valid_o, .uop_store_o, .uop_reg_o, .uop_addr_o,
    .busy_o, .done_o, .abort_o, .wb_valid_o, .wb_addr_o
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit next_ready();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return |lf[1:0];
  endfunction

  task automatic run_op(input logic [NR-1:0] m, input bit st, input bit stk,
                        input logic [31:0] base, input bit wbe, input int fault_k,
                        input bit poke, input string rtag);
    int n = 0;
    int regs[NR];
    logic [31:0] first, fin;
    int k = 0;
    int guard = 0;
    bit stalled = 0;
    bit poked = 0;
    string tg, atg;
    for (int i = 0; i < NR; i++) if (m[i]) begin regs[n] = i; n++; end
    fin   = (st && stk) ? base - 32'(4 * n) : base + 32'(4 * n);
    first = (st && stk) ? fin : base;

    @(negedge clk);
    start_i = 1; mask_i = m; store_i = st; stack_i = stk; base_i = base; wb_en_i = wbe;
    ready_i = 0; fault_i = 0;
    @(negedge clk);
    start_i = 0;
    if (n == 0) begin
      chk(done_o === 1'b1, "R5 done", 32'(done_o), 1);
      chk(uop_valid_o === 1'b0, "R5 valid", 32'(uop_valid_o), 0);
      chk(wb_valid_o === wbe, "R6 wb strobe", 32'(wb_valid_o), 32'(wbe));
      if (wbe) chk(wb_addr_o === base, "R6 wb addr", wb_addr_o, base);
      @(negedge clk);
      chk(done_o === 1'b0, "R5 pulse", 32'(done_o), 0);
      return;
    end
    while (k < n && guard < 400) begin
      tg  = poked ? "R9" : (stalled ? "R4" : rtag);
      atg = poked ? "R9" : (stalled ? "R4" : (rtag == "R2" ? "R3" : rtag));
      chk(uop_valid_o === 1'b1, {tg, " valid"}, 32'(uop_valid_o), 1);
      chk(uop_reg_o === 3'(regs[k]), {tg, " reg"}, 32'(uop_reg_o), 32'(regs[k]));
      chk(uop_addr_o === first + 32'(4 * k), {atg, " addr"}, uop_addr_o, first + 32'(4 * k));
      chk(uop_store_o === st, "R3 dir", 32'(uop_store_o), 32'(st));
      if (k == fault_k) begin
        fault_i = 1; ready_i = next_ready();
        @(negedge clk);
        fault_i = 0; ready_i = 0;
        chk(abort_o === 1'b1, "R7 abort", 32'(abort_o), 1);
        chk(uop_valid_o === 1'b0, "R7 valid", 32'(uop_valid_o), 0);
        chk(done_o === 1'b0, "R7 done", 32'(done_o), 0);
        chk(wb_valid_o === 1'b0, "R7 wb", 32'(wb_valid_o), 0);
        @(negedge clk);
        chk(abort_o === 1'b0, "R7 pulse", 32'(abort_o), 0);
        chk(busy_o === 1'b0, "R7 idle", 32'(busy_o), 0);
        return;
      end
      if (poke && !poked) begin
        start_i = 1; mask_i = '1; base_i = base ^ 32'h00F0_0000; poked = 1;
      end else begin
        poked = 0;
      end
      ready_i = next_ready();
      stalled = !ready_i;
      @(negedge clk);
      start_i = 0;
      if (ready_i) k++;
      guard++;
    end
    ready_i = 0;
    chk(done_o === 1'b1, "R6 done", 32'(done_o), 1);
    chk(uop_valid_o === 1'b0, "R6 valid", 32'(uop_valid_o), 0);
    chk(wb_valid_o === wbe, "R6 wb strobe", 32'(wb_valid_o), 32'(wbe));
    if (wbe) chk(wb_addr_o === fin, "R6 wb addr", wb_addr_o, fin);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 pulse", 32'(done_o), 0);
  endtask

  initial begin
    rst_n = 0; start_i = 0; store_i = 0; stack_i = 0; wb_en_i = 0;
    mask_i = '0; base_i = '0; ready_i = 0; fault_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(uop_valid_o === 1'b0, "R1 valid", 32'(uop_valid_o), 0);
    chk(busy_o === 1'b0, "R1 busy", 32'(busy_o), 0);
    chk(done_o === 1'b0, "R1 done", 32'(done_o), 0);
    chk(abort_o === 1'b0, "R1 abort", 32'(abort_o), 0);
    chk(wb_valid_o === 1'b0, "R1 wb", 32'(wb_valid_o), 0);

    // R10: fault while idle
    fault_i = 1;
    @(negedge clk);
    fault_i = 0;
    chk(abort_o === 1'b0, "R10 abort", 32'(abort_o), 0);
    chk(uop_valid_o === 1'b0, "R10 valid", 32'(uop_valid_o), 0);
    @(negedge clk);
    chk(abort_o === 1'b0, "R10 later", 32'(abort_o), 0);

    // exhaustive mask sweep over all direction / stack forms (R2 R3 R4 R5 R6 R9)
    for (int m = 0; m < 256; m++) begin
      for (int md = 0; md < 4; md++) begin
        run_op(8'(m), md[0], md[1], 32'h0000_8000 + 32'(m * 64),
               m[1] ^ md[0], -1, (m % 7) == 3, "R2");
      end
    end

    // R7 / R8: repeated aborts of a push at early and late positions, then replay
    run_op(8'hA5, 1, 1, 32'h0000_2000, 1, 0, 0, "R8");
    run_op(8'hA5, 1, 1, 32'h0000_2000, 1, 3, 0, "R8");
    run_op(8'hA5, 1, 1, 32'h0000_2000, 1, 1, 0, "R8");
    run_op(8'hA5, 1, 1, 32'h0000_2000, 1, -1, 0, "R8");
    // pop form aborted late then replayed
    run_op(8'hFF, 0, 1, 32'h0000_3FF0, 1, 7, 0, "R8");
    run_op(8'hFF, 0, 1, 32'h0000_3FF0, 1, -1, 0, "R8");
    // general-base store aborted on its first part
    run_op(8'h3C, 1, 0, 32'h0001_0000, 0, 0, 0, "R7");
    run_op(8'h3C, 1, 0, 32'h0001_0000, 0, -1, 0, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule